// File: doc/BRIEF.md
# CPU Reset Sequencer with Hold Gating

This block decides when a CPU reset requested by software may reach the CPU. It gates that reset against the CPU hold handshake. A configuration bit selects one of two policies. In legacy mode the reset is held back for as long as the CPU has granted hold. In safe mode the block raises its own hold request first, and fires the reset only once the hold line and the acknowledge are both active. The CPU is then parked off the bus, so the control lines that a reset drives high cannot turn an in-flight read into a memory write. Other masters may keep using the bus while the reset pulse runs.

Power-good has priority over everything else. While power-good is low, the CPU reset output is driven high directly. When power-good rises, an ordinary reset pulse follows with no hold gating. Any pending software sequence is dropped.

The reset pulse lasts `PULSE_LEN` clocks (default 16). Software requests that arrive while a sequence is running are absorbed. The mode bit is captured when a request is accepted.

Top module: `cpu_rst_seq`

## Requirements
- R1: With mode 0 (legacy), an accepted request asserts `cpu_rst_o` after the first clock edge at which `hlda_i` is sampled low. `cpu_rst_o` never rises while `hlda_i` was high at the preceding edge.
- R2: With mode 1 (safe), `hold_req_o` goes high after the clock edge that accepts the request. A request is accepted at an edge where the block is idle and `rst_req_i` is high.
- R3: In safe mode, `cpu_rst_o` rises after the first edge at which `hold_i` and `hlda_i` are both sampled high, and not earlier.
- R4: A software reset pulse or a power-on reset pulse keeps `cpu_rst_o` high for exactly `PULSE_LEN` clock cycles.
- R5: In safe mode, `hold_req_o` stays high through the pulse and drops together with `cpu_rst_o`. In legacy mode, `hold_req_o` stays low throughout.
- R6: While `pwr_good_i` is low, `cpu_rst_o` is high and `hold_req_o` is low at once. Any pending or running sequence is discarded.
- R7: After the edge at which `pwr_good_i` is first sampled high, `cpu_rst_o` stays high for `PULSE_LEN` more cycles whatever `hold_i`/`hlda_i` show. It does not drop in between.
- R8: `rst_req_i` is ignored while a sequence (waiting or pulsing) is in progress. It neither extends the pulse nor queues a second one.
- R9: The mode bit is captured at acceptance. Changing `mode_i` afterwards does not alter the gating or the hold request of that sequence.
- R10: Under reset (`rst_ni` low), `hold_req_o` is 0 and `cpu_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_req_i | input | 1 | Software CPU reset request |
| mode_i | input | 1 | Gating policy: 0 legacy, 1 safe (hold-gated) |
| hold_i | input | 1 | HOLD line as seen at the CPU (all sources combined) |
| hlda_i | input | 1 | CPU hold acknowledge |
| pwr_good_i | input | 1 | Power-good; low forces reset, rising starts a power-on pulse |
| cpu_rst_o | output | 1 | Reset to the CPU |
| hold_req_o | output | 1 | Hold request from this block into the arbiter |

## Verification
The hardest situations to reach combine a sequence already in flight with a second event. Examples are power-good dropping while a safe-mode sequence waits for the acknowledge, `mode_i` flipping while a legacy sequence waits, and a new request arriving mid-pulse. The stimulus first parks the sequencer in its waiting state by holding `hlda_i` high (legacy) or withholding the acknowledge (safe). It then injects the second event for a few cycles before releasing the handshake. A cycle-level reference model compares both outputs on every clock.

// File: rtl/cpu_rst_seq_pkg.sv
package cpu_rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WFREE = 2'd1,  // legacy: wait for hold to end
    ST_WACK  = 2'd2,  // safe: hold requested, wait for ack
    ST_PULSE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cpu_rst_seq_edge.sv
module cpu_rst_seq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  logic q_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d_i;
  assign q_o    = q_q;
  assign rise_o = d_i & ~q_q;
endmodule

// File: rtl/cpu_rst_seq_timer.sv
module cpu_rst_seq_timer #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign done_o = (cnt_q == '0);

  // R4: count never exceeds the loaded value
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  // R4: while running, counter moves down by one each cycle
  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_seq_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_i,
  input  logic mode_i,
  input  logic hold_i,
  input  logic hlda_i,
  input  logic pwr_good_i,
  output logic cpu_rst_o,
  output logic hold_req_o
);
  seq_state_e state_q, state_d;
  logic safe_q, safe_d;
  logic load;
  logic done;
  logic pg_q, pg_rise;

  cpu_rst_seq_edge u_pg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_good_i),
    .q_o   (pg_q),
    .rise_o(pg_rise)
  );

  cpu_rst_seq_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .run_i (state_q == ST_PULSE),
    .done_o(done)
  );

  always_comb begin
    state_d = state_q;
    safe_d  = safe_q;
    load    = 1'b0;
    if (!pwr_good_i) begin
      state_d = ST_IDLE;
      safe_d  = 1'b0;
    end else if (pg_rise) begin
      state_d = ST_PULSE;  // power-on: no gating
      safe_d  = 1'b0;
      load    = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rst_req_i) begin
          safe_d  = mode_i;
          state_d = mode_i ? ST_WACK : ST_WFREE;
        end
        ST_WFREE: if (!hlda_i) begin
          state_d = ST_PULSE;
          load    = 1'b1;
        end
        ST_WACK: if (hold_i && hlda_i) begin
          state_d = ST_PULSE;
          load    = 1'b1;
        end
        ST_PULSE: if (done) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      safe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      safe_q  <= safe_d;
    end

  // pg_q keeps reset high across the power-good rising edge
  assign cpu_rst_o  = ~pwr_good_i | ~pg_q | (state_q == ST_PULSE);
  assign hold_req_o = pwr_good_i &
                      ((state_q == ST_WACK) | (state_q == ST_PULSE && safe_q));

  assert_legacy_no_rst_in_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_rst_o) && pwr_good_i && !safe_q) |-> $past(!hlda_i));
  assert_safe_rst_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_rst_o) && pwr_good_i && safe_q) |-> $past(hold_i && hlda_i));
  assert_hold_drops_with_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cpu_rst_o) && pwr_good_i) |-> !hold_req_o);
  assert_pg_low_no_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (cpu_rst_o && (!pwr_good_i || !hold_req_o)));
  assert_pg_rise_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_good_i) |=> cpu_rst_o);
  assert_safe_req_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rst_req_i && mode_i && pwr_good_i && pg_q) |=>
      (hold_req_o || !pwr_good_i));
endmodule

// File: tb/sim_cpu_rst_seq.sv
module sim_cpu_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, mode = 1'b0, hold = 1'b0, hlda = 1'b0, pg = 1'b0;
  logic cpu_rst, hold_req;

  cpu_rst_seq #(.PULSE_LEN(LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(req), .mode_i(mode),
    .hold_i(hold), .hlda_i(hlda), .pwr_good_i(pg),
    .cpu_rst_o(cpu_rst), .hold_req_o(hold_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 idle, 1 wait hold end, 2 wait ack, 3 pulse
  int m_phase, m_cnt;
  bit m_safe, m_pg_prev;
  int n_vec = 0, n_bad = 0, cycles = 0;
  string tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_safe = 0; m_pg_prev = 0;
    end else begin
      bit rise;
      rise = pg && !m_pg_prev;
      m_pg_prev = pg;
      if (!pg) begin
        m_phase = 0; m_safe = 0;
      end else if (rise) begin
        m_phase = 3; m_cnt = LEN; m_safe = 0;
      end else begin
        case (m_phase)
          0: if (req) begin m_safe = mode; m_phase = mode ? 2 : 1; end
          1: if (!hlda) begin m_phase = 3; m_cnt = LEN; end
          2: if (hold && hlda) begin m_phase = 3; m_cnt = LEN; end
          default: begin m_cnt--; if (m_cnt == 0) m_phase = 0; end
        endcase
      end
    end
  end

  task automatic compare();
    bit e_rst, e_hold;
    e_rst  = !pg || !m_pg_prev || (m_phase == 3);
    e_hold = pg && ((m_phase == 2) || (m_phase == 3 && m_safe));
    n_vec++;
    if (cpu_rst !== e_rst) begin
      n_bad++;
      $display("FAIL %s cpu_rst_o=%b expected %b at cycle %0d", tag, cpu_rst, e_rst, cycles);
    end
    if (hold_req !== e_hold) begin
      n_bad++;
      $display("FAIL %s hold_req_o=%b expected %b at cycle %0d", tag, hold_req, e_hold, cycles);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      compare();
    end
  endtask

  task automatic pulse_req();
    req = 1'b1; cyc(1); req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    tag = "R10"; cyc(3);
    pg = 1'b1; cyc(2);
    rst_n = 1'b1;
    // R7: power-on pulse right after reset release, hold ignored
    tag = "R7"; hlda = 1'b1; hold = 1'b1; cyc(LEN + 3);
    hlda = 1'b0; hold = 1'b0;
    // R6: power-good drop and rise
    tag = "R6"; pg = 1'b0; cyc(4);
    tag = "R7"; pg = 1'b1; hlda = 1'b1; cyc(LEN + 3); hlda = 1'b0;

    // R1: legacy, CPU in hold delays reset
    tag = "R1"; mode = 1'b0; hlda = 1'b1; hold = 1'b1; pulse_req(); cyc(6);
    tag = "R8"; pulse_req(); cyc(2);             // absorbed while waiting
    tag = "R4"; hlda = 1'b0; hold = 1'b0; cyc(LEN + 4);
    // R5: legacy never requests hold
    tag = "R5"; pulse_req(); cyc(LEN + 4);

    // R2/R3: safe mode handshake
    tag = "R2"; mode = 1'b1; pulse_req(); cyc(2);
    tag = "R3"; hold = 1'b1; cyc(3);             // hold without ack
    tag = "R9"; mode = 1'b0; cyc(2);             // mode flip mid-wait
    tag = "R3"; hlda = 1'b1; cyc(3);
    tag = "R8"; pulse_req(); cyc(3);             // request mid-pulse
    tag = "R5"; hold = 1'b0; hlda = 1'b0; cyc(LEN + 3);

    // R6: power-good drop while safe sequence waits for ack
    tag = "R6"; mode = 1'b1; pulse_req(); cyc(3);
    pg = 1'b0; cyc(3);
    tag = "R7"; pg = 1'b1; cyc(LEN + 3);

    // R9: legacy accepted, mode set to safe while waiting
    tag = "R9"; mode = 1'b0; hlda = 1'b1; pulse_req(); cyc(1);
    mode = 1'b1; hold = 1'b1; cyc(4);
    hlda = 1'b0; hold = 1'b0; cyc(LEN + 3);

    // R4: safe pulse with ack arriving on the accept cycle
    tag = "R4"; mode = 1'b1; hold = 1'b1; hlda = 1'b1; pulse_req(); cyc(LEN + 4);
    hold = 1'b0; hlda = 1'b0; cyc(3);

    // R10: asynchronous reset mid-pulse
    tag = "R10"; mode = 1'b0; pulse_req(); cyc(4);
    rst_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(LEN + 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule